// File: doc/BRIEF.md
# Recovered Clock Frequency Classifier

This block works out how fast a recovered receiver clock runs, for example the output of a PLL locked to an incoming digital audio stream. It compares that clock with a reference oscillator clock of known frequency. A free-running counter in the recovered domain is snapshotted once per gate window of `GATE_CYC` reference cycles. Each snapshot crosses into the reference domain through a toggle request/acknowledge handshake with two-flop synchronizers. The difference between two consecutive snapshots is the raw ratio: recovered edges per gate window. Software that knows its reference frequency can compute the absolute clock rate from this value.

The raw ratio is also classified to the nearest of eight standard audio master-clock frequencies. The thresholds are the midpoints between neighbouring table entries, converted to counts for the selected reference frequency. They are computed as elaboration-time constants.

The reference-domain controller is a four-state machine:
- `ST_START` waits for the first window end and then fires a request (transition *arm*).
- `ST_BASE` waits for an acknowledge and stores a baseline snapshot (*baseline*). A window end with no acknowledge is *starve*.
- `ST_RUN` waits for the next window end and fires a request (*sample*).
- `ST_WAIT` takes the acknowledged snapshot as a result (*result*). If another window ends with no acknowledge, it reports a dead clock and falls back to `ST_BASE` (*starve*).

Top module: `rclk_freq_classifier`

## Requirements
- R1: While `rst_n` is low at a rising `ref_clk` edge, the next cycle shows `ratio_out` = 0, `code_valid` = 0 and `freq_code` = 000.
- R2: With a running recovered clock, `ratio_out` settles to the number of `rec_clk` rising edges per `GATE_CYC` reference cycles, within ±1 count.
- R3: `freq_code` gives the table frequency nearest to the measured one: 000 = 8.192 MHz, 001 = 11.2896 MHz, 010 = 12.288 MHz, 011 = 16.384 MHz, 100 = 22.5792 MHz, 101 = 24.576 MHz, 110 = 45.1584 MHz, 111 = 49.152 MHz.
- R4: `ref_sel` names the reference frequency: 00 = 12.288 MHz, 01 = 18.432 MHz, 10 = 24.576 MHz. The thresholds scale with this selection, so the same clock gets the same code under every supported reference.
- R5: With `ref_sel` = 11 (unsupported reference), `ratio_out` keeps updating but `code_valid` stays 0 from the cycle after the selection.
- R6: With `force_lock` = 1 at a rising edge, `freq_code` is 111 in the next cycle, whatever the measurement. Once `force_lock` returns to 0, the classified code returns.
- R7: `code_valid` stays 0 until the first full window after reset has completed and its result has been taken. After that it is 1 while the recovered clock runs.
- R8: A change of `ref_sel` clears `code_valid` in the next cycle. The next result is discarded for validity, so `code_valid` comes back only after a full window measured under the new selection.
- R9: If a whole gate window passes while a request is still unacknowledged (no recovered edges), `ratio_out` becomes 0 and `code_valid` becomes 0. A baseline is taken again once edges return.
- R10: The snapshot crossing to the reference domain changes only together with a toggle of the acknowledge, and a valid result is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock; all outputs are in this domain |
| rst_n | input | 1 | Active-low synchronous reset (reference domain; resynchronized for the recovered side) |
| rec_clk | input | 1 | Recovered receiver clock under measurement |
| ref_sel | input | 2 | Reference frequency selection (00, 01, 10 supported; 11 unsupported) |
| force_lock | input | 1 | Forces `freq_code` to 111 |
| ratio_out | output | CNT_W | Recovered edges counted per gate window |
| freq_code | output | 3 | Nearest table frequency code |
| code_valid | output | 1 | Measurement complete and reference supported |

## Verification
The assertions watch the following on every cycle:
- the reset clearing;
- the forced code one cycle after `force_lock`;
- validity dropping after any selection change and under the unsupported selection;
- the rule that a valid ratio is never zero;
- the stability of the crossing snapshot between acknowledges.

Whether the ratio really counts edges per window, and whether the classification picks the nearest table entry under each reference, can only be seen through the bench. Its sweeps drive every table frequency, slightly above and below nominal, under all three references. The same holds for validity returning after a selection change and recovery after the recovered clock stops and restarts.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int NUM_CODES = 8;
    localparam int CODE_W    = 3;
    localparam int NUM_REFS  = 3;
    localparam logic [1:0] SEL_NONE = 2'b11;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_BASE  = 2'd1,
        ST_RUN   = 2'd2,
        ST_WAIT  = 2'd3
    } meas_state_e;

    // Table frequencies in units of 100 Hz, ascending, indexed by code.
    function automatic longint tbl_freq(input int idx);
        case (idx)
            0:       return 64'd81920;
            1:       return 64'd112896;
            2:       return 64'd122880;
            3:       return 64'd163840;
            4:       return 64'd225792;
            5:       return 64'd245760;
            6:       return 64'd451584;
            default: return 64'd491520;
        endcase
    endfunction

    // Reference frequencies in units of 100 Hz, indexed by selection.
    function automatic longint ref_freq(input int sel);
        case (sel)
            0:       return 64'd122880;
            1:       return 64'd184320;
            default: return 64'd245760;
        endcase
    endfunction

    // Count at the midpoint between entries idx and idx+1.
    function automatic longint thr_count(input int sel, input int idx, input int gate);
        return ((tbl_freq(idx) + tbl_freq(idx + 1)) * longint'(gate)) / (2 * ref_freq(sel));
    endfunction

endpackage

// File: rtl/rcf_sync2.sv
module rcf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rcf_rec_sampler.sv
module rcf_rec_sampler #(
    parameter int CNT_W = 16
) (
    input  logic             rec_clk,
    input  logic             rst_n,
    input  logic             req_t,
    output logic [CNT_W-1:0] snap,
    output logic             ack_t
);
    logic [1:0]       rst_pipe;
    logic             rec_rst_n;
    logic             req_s;
    logic             req_seen;
    logic [CNT_W-1:0] edge_cnt;

    // reset brought into the recovered domain
    always_ff @(posedge rec_clk) begin
        rst_pipe <= {rst_pipe[0], rst_n};
    end
    assign rec_rst_n = rst_pipe[1];

    rcf_sync2 #(.W(1)) u_req_sync (
        .clk   (rec_clk),
        .rst_n (rec_rst_n),
        .d     (req_t),
        .q     (req_s)
    );

    always_ff @(posedge rec_clk) begin
        if (!rec_rst_n) begin
            edge_cnt <= '0;
            snap     <= '0;
            ack_t    <= 1'b0;
            req_seen <= 1'b0;
        end else begin
            edge_cnt <= edge_cnt + 1'b1;
            req_seen <= req_s;
            if (req_s != req_seen) begin
                snap  <= edge_cnt;
                ack_t <= ~ack_t;
            end
        end
    end

    // R10
    snap_hold_chk: assert property (@(posedge rec_clk) disable iff (!rec_rst_n)
        (snap != $past(snap)) |-> (ack_t != $past(ack_t)));
endmodule

// File: rtl/rcf_classifier.sv
module rcf_classifier #(
    parameter int CNT_W    = 16,
    parameter int GATE_CYC = 2048
) (
    input  logic [CNT_W-1:0]          ratio,
    input  logic [1:0]                sel,
    output logic [rcf_pkg::CODE_W-1:0] code
);
    import rcf_pkg::*;

    localparam int NTHR = NUM_CODES - 1;

    logic [NTHR-1:0] above [NUM_REFS];
    logic [NTHR-1:0] row;

    for (genvar s = 0; s < NUM_REFS; s++) begin : g_ref
        for (genvar i = 0; i < NTHR; i++) begin : g_thr
            localparam longint THR = thr_count(s, i, GATE_CYC);
            assign above[s][i] = (longint'(ratio) >= THR);
        end
    end

    always_comb begin
        unique case (sel)
            2'b01:   row = above[1];
            2'b10:   row = above[2];
            default: row = above[0];
        endcase
        code = CODE_W'($countones(row));
    end
endmodule

// File: rtl/rclk_freq_classifier.sv
module rclk_freq_classifier #(
    parameter int CNT_W    = 16,
    parameter int GATE_CYC = 2048
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             rec_clk,
    input  logic [1:0]       ref_sel,
    input  logic             force_lock,
    output logic [CNT_W-1:0] ratio_out,
    output logic [2:0]       freq_code,
    output logic             code_valid
);
    import rcf_pkg::*;

    localparam int GATE_W = $clog2(GATE_CYC);

    meas_state_e      state, next_state;
    logic [GATE_W-1:0] gate_cnt;
    logic             tick;
    logic             req_t;
    logic             ack_t;
    logic             ack_s;
    logic             ack_seen;
    logic             ack_evt;
    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] base_q;
    logic [1:0]       sel_q;
    logic             sel_chg;
    logic             stale_q;
    logic             issue_req;
    logic             take_base;
    logic             take_result;
    logic             starve;
    logic [CODE_W-1:0] class_code;

    rcf_rec_sampler #(.CNT_W(CNT_W)) u_sampler (
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .req_t   (req_t),
        .snap    (snap),
        .ack_t   (ack_t)
    );

    rcf_sync2 #(.W(1)) u_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (ack_t),
        .q     (ack_s)
    );

    rcf_classifier #(.CNT_W(CNT_W), .GATE_CYC(GATE_CYC)) u_class (
        .ratio (ratio_out),
        .sel   (ref_sel),
        .code  (class_code)
    );

    assign tick    = (gate_cnt == GATE_W'(GATE_CYC - 1));
    assign ack_evt = (ack_s != ack_seen);
    assign sel_chg = (ref_sel != sel_q);

    // state register
    always_ff @(posedge ref_clk) begin
        if (!rst_n) state <= ST_START;
        else        state <= next_state;
    end

    // transitions: arm, baseline, sample, result, starve
    always_comb begin
        next_state  = state;
        issue_req   = 1'b0;
        take_base   = 1'b0;
        take_result = 1'b0;
        starve      = 1'b0;
        unique case (state)
            ST_START: begin
                if (tick) begin
                    issue_req  = 1'b1;
                    next_state = ST_BASE;
                end
            end
            ST_BASE: begin
                if (ack_evt) begin
                    take_base = 1'b1;
                    if (tick) begin
                        issue_req  = 1'b1;
                        next_state = ST_WAIT;
                    end else begin
                        next_state = ST_RUN;
                    end
                end else if (tick) begin
                    starve = 1'b1;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    issue_req  = 1'b1;
                    next_state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ack_evt) begin
                    take_result = 1'b1;
                    if (tick) begin
                        issue_req  = 1'b1;
                        next_state = ST_WAIT;
                    end else begin
                        next_state = ST_RUN;
                    end
                end else if (tick) begin
                    starve     = 1'b1;
                    next_state = ST_BASE;
                end
            end
        endcase
    end

    // datapath and outputs
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            gate_cnt   <= '0;
            req_t      <= 1'b0;
            ack_seen   <= 1'b0;
            sel_q      <= ref_sel;
            stale_q    <= 1'b0;
            base_q     <= '0;
            ratio_out  <= '0;
            code_valid <= 1'b0;
            freq_code  <= '0;
        end else begin
            gate_cnt <= tick ? '0 : gate_cnt + 1'b1;
            ack_seen <= ack_s;
            sel_q    <= ref_sel;
            if (issue_req) req_t <= ~req_t;
            if (take_base || take_result) base_q <= snap;
            if (take_result)  ratio_out <= snap - base_q;
            else if (starve)  ratio_out <= '0;
            if (sel_chg || starve)
                code_valid <= 1'b0;
            else if (take_result)
                code_valid <= !stale_q && (sel_q != SEL_NONE);
            if (sel_chg)          stale_q <= 1'b1;
            else if (take_result) stale_q <= 1'b0;
            freq_code <= force_lock ? 3'b111 : class_code;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge ref_clk)
        !rst_n |=> (ratio_out == '0 && !code_valid && freq_code == 3'b000));

    // R6
    force_code_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        force_lock |=> (freq_code == 3'b111));

    // R8
    sel_change_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_sel != $past(ref_sel)) |=> !code_valid);

    // R5
    unsupported_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_sel == SEL_NONE) |=> !code_valid);

    // R10
    valid_nonzero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        code_valid |-> (ratio_out != '0));
endmodule

// File: tb/rclk_freq_classifier_tb_top.sv
module rclk_freq_classifier_tb_top;

    localparam int CNT_W  = 16;
    localparam int GATE   = 256;
    localparam int REF_PS = 8000;

    logic             ref_clk = 1'b0;
    logic             rec_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic [1:0]       ref_sel = 2'b00;
    logic             force_lock = 1'b0;
    logic [CNT_W-1:0] ratio_out;
    logic [2:0]       freq_code;
    logic             code_valid;

    int     rec_half = 4000;
    bit     rec_run  = 1'b1;
    int     checks   = 0;
    int     errors   = 0;
    int     cyc      = 0;
    bit     done     = 1'b0;
    real    exp_ratio;
    int     exp_code;
    longint tbl [8];
    longint refs [3];

    rclk_freq_classifier #(.CNT_W(CNT_W), .GATE_CYC(GATE)) dut_i (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .rec_clk    (rec_clk),
        .ref_sel    (ref_sel),
        .force_lock (force_lock),
        .ratio_out  (ratio_out),
        .freq_code  (freq_code),
        .code_valid (code_valid)
    );

    // 125 MHz, delays in ps
    initial forever #(REF_PS / 2) ref_clk = ~ref_clk;

    always begin
        if (rec_run) begin
            #(rec_half) rec_clk = ~rec_clk;
        end else begin
            #1000;
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge ref_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    // f in 100 Hz units, fref the reference it stands for
    task automatic set_rec(input real f, input longint fref);
        longint per;
        per = longint'((real'(REF_PS) * real'(fref)) / f + 0.5);
        rec_half  = int'(per / 2);
        exp_ratio = real'(GATE) * real'(REF_PS) / real'(2 * rec_half);
        exp_code  = 0;
        for (int j = 1; j < 8; j++) begin
            real dj, db;
            dj = (real'(tbl[j]) > f) ? real'(tbl[j]) - f : f - real'(tbl[j]);
            db = (real'(tbl[exp_code]) > f) ? real'(tbl[exp_code]) - f : f - real'(tbl[exp_code]);
            if (dj < db) exp_code = j;
        end
    endtask

    function automatic bit ratio_ok();
        real d;
        d = real'(ratio_out) - exp_ratio;
        return (d <= 1.5) && (d >= -1.5);
    endfunction

    initial begin
        tbl[0] = 81920;  tbl[1] = 112896; tbl[2] = 122880; tbl[3] = 163840;
        tbl[4] = 225792; tbl[5] = 245760; tbl[6] = 451584; tbl[7] = 491520;
        refs[0] = 122880; refs[1] = 184320; refs[2] = 245760;

        set_rec(real'(tbl[3]), refs[0]);
        wait_cyc(5);
        // R1 during reset
        check(ratio_out == 0, "R1", "ratio in reset", ratio_out, 0);
        check(code_valid == 0, "R1", "valid in reset", code_valid, 0);
        check(freq_code == 0, "R1", "code in reset", freq_code, 0);
        wait_cyc(15);
        rst_n = 1'b1;

        // R7: no valid before first complete window
        wait_cyc(2 * GATE - 12);
        check(code_valid == 0, "R7", "valid before first window", code_valid, 0);
        wait_cyc(60);
        check(code_valid == 1, "R7", "valid after first window", code_valid, 1);
        check(ratio_ok(), "R2", "first ratio", ratio_out, longint'(exp_ratio));

        // R2 R3 R4 sweep: every table entry, every supported reference
        for (int s = 0; s < 3; s++) begin
            ref_sel = 2'(s);
            for (int i = 0; i < 8; i++) begin
                real fac;
                fac = (i % 3 == 1) ? 1.025 : ((i % 3 == 2) ? 0.975 : 1.0);
                set_rec(real'(tbl[i]) * fac, refs[s]);
                wait_cyc(3 * GATE + 20);
                check(ratio_ok(), "R2 R10", "ratio", ratio_out, longint'(exp_ratio));
                check(freq_code == 3'(exp_code), "R3 R4", "code", freq_code, exp_code);
                check(code_valid == 1, "R4", "valid", code_valid, 1);
            end
        end

        // R5: unsupported reference
        ref_sel = 2'b11;
        set_rec(real'(tbl[3]), refs[0]);
        wait_cyc(3 * GATE + 20);
        check(code_valid == 0, "R5", "valid unsupported", code_valid, 0);
        check(ratio_ok(), "R5", "ratio unsupported", ratio_out, longint'(exp_ratio));

        // R8: selection change clears valid, returns after a full window
        ref_sel = 2'b00;
        wait_cyc(3 * GATE + 20);
        check(code_valid == 1, "R8", "valid before change", code_valid, 1);
        ref_sel = 2'b01;
        wait_cyc(1);
        check(code_valid == 0, "R8", "valid after change", code_valid, 0);
        set_rec(real'(tbl[3]), refs[1]);
        wait_cyc(3 * GATE + 20);
        check(code_valid == 1, "R8", "valid restored", code_valid, 1);
        check(freq_code == 3'(exp_code), "R8", "code after change", freq_code, exp_code);

        // R6: force
        force_lock = 1'b1;
        wait_cyc(1);
        check(freq_code == 3'b111, "R6", "forced code", freq_code, 7);
        wait_cyc(5);
        check(freq_code == 3'b111, "R6", "forced code held", freq_code, 7);
        force_lock = 1'b0;
        wait_cyc(2);
        check(freq_code == 3'(exp_code), "R6", "code after release", freq_code, exp_code);

        // R9: dead recovered clock
        rec_run = 1'b0;
        wait_cyc(3 * GATE + 20);
        check(ratio_out == 0, "R9", "ratio dead clock", ratio_out, 0);
        check(code_valid == 0, "R9", "valid dead clock", code_valid, 0);
        rec_run = 1'b1;
        wait_cyc(4 * GATE + 20);
        check(code_valid == 1, "R9", "valid after restart", code_valid, 1);
        check(ratio_ok(), "R9", "ratio after restart", ratio_out, longint'(exp_ratio));

        // R1: reset mid-run
        rst_n = 1'b0;
        wait_cyc(1);
        check(ratio_out == 0, "R1", "ratio mid reset", ratio_out, 0);
        check(code_valid == 0, "R1", "valid mid reset", code_valid, 0);
        check(freq_code == 0, "R1", "code mid reset", freq_code, 0);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule